// File: doc/BRIEF.md
# I2C Slave Controller with Per-Event Interrupts

This block is a 7-bit-address I2C target that sits behind a small register port of a CPU. It samples SCL and SDA through a synchronizer and detects START and STOP conditions. It shifts in the address byte and answers it. It then receives bytes from the master or sends bytes to it, and it pulls SDA low through an open-drain enable whenever it drives a 0.

Four bus events each set their own sticky flag: START seen, byte received, byte sent, and STOP while addressed. Each flag has an enable bit. The interrupt line is high while any flag and its enable are both 1. A busy bit shows that the block has been addressed since the last STOP. Software can return the bus engine to idle at any time through a self-clearing reset bit.

Register map (2-bit address): 0 control, 1 status, 2 own address in bits 6:0, 3 data. A write to address 3 loads the byte to transmit. A read from address 3 returns the last byte received.

Top module: `i2c_evt_slave`

## Requirements
- R1: After rst_ni, every register reads 0x00, irq_o is 0 and sda_oe_o is 0.
- R2: A START (SDA falling while SCL is high) sets the START flag, status bit 6.
- R3: If the address byte after a START carries the programmed 7-bit address in bits 7:1, the slave pulls SDA low during the 9th clock and sets busy (status bit 7). On a mismatch it leaves SDA released and busy at 0.
- R4: Busy stays at 1 until a STOP (SDA rising while SCL is high). The STOP clears busy. It sets the STOP flag (status bit 3) only if busy was 1.
- R5: In a write transfer the receive flag (status bit 5) is set at the falling SCL edge of the 8th data bit. The byte, MSB first, then reads back at address 3.
- R6: On a received data byte the 9th clock carries the level of status bit 0: 0 pulls SDA low (ACK), 1 leaves it released (NACK).
- R7: In a read transfer (address bit 0 = 1) the byte written at address 3 goes out MSB first. The transmit flag (status bit 4) is set after the 8th bit. Status bit 1 holds the SDA level the master gave in the 9th clock. After an ACK (0) the slave sends the byte again; after a NACK (1) it stops driving.
- R8: Writing 0 to a status flag bit clears it. Writing 1 to it has no effect. A flag stays set until it is cleared.
- R9: irq_o is 1 exactly when some flag is 1 and its enable is 1. The enables are control bits 6 (START), 5 (receive), 4 (transmit) and 3 (STOP).
- R10: Writing 1 to control bit 0 returns the bus engine to idle, clears busy and releases SDA. The bit always reads 0.
- R11: Busy, status bit 7, is read-only: a status write does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong bus-engine state shows at the pins within one SCL period. The acknowledge slot is either pulled low when it should be released or left released when it should be pulled, and read data comes out shifted or inverted. A wrong busy or flag register shows at the next status read and on irq_o. The bench therefore samples the 9th-clock SDA level and every status and interrupt value after each bus phase. It compares them with a behavioural model of the flags, busy bit and acknowledge state.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int CNT_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_RX, ST_RACK, ST_TX, ST_TACK, ST_SKIP
  } slv_state_e;

  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_STAT = 2'd1;
  localparam logic [1:0] RA_SADR = 2'd2;
  localparam logic [1:0] RA_DATA = 2'd3;

  // event index inside the 4-bit flag/enable vectors (maps to reg bits 6:3)
  localparam int EV_START = 3;
  localparam int EV_RX    = 2;
  localparam int EV_TX    = 1;
  localparam int EV_STOP  = 0;
  localparam int EV_N     = 4;
endpackage

// File: rtl/i2c_evt_sync.sv
module i2c_evt_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] in_i,
  output logic [LINES-1:0] out_o
);
  logic [LINES-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe[0] <= '1;
        else         pipe[0] <= in_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe[s] <= '1;
        else         pipe[s] <= pipe[s-1];
      end
    end
  end

  assign out_o = pipe[STAGES-1];
endmodule

// File: rtl/i2c_evt_cond.sv
module i2c_evt_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  // SDA transitions only count while SCL was and is high
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_evt_fsm.sv
module i2c_evt_fsm
  import i2c_evt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  input  logic              ack_cfg_i,
  output logic              busy_o,
  output logic              sda_oe_o,
  output logic              ack_in_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic [EV_N-1:0]   evt_o
);
  slv_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic              rw_q, busy_q, oe_q, ack_in_q;
  logic [EV_N-1:0]   evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      rw_q      <= 1'b0;
      busy_q    <= 1'b0;
      oe_q      <= 1'b0;
      ack_in_q  <= 1'b0;
      rx_data_o <= '0;
      evt_q     <= '0;
    end else begin
      evt_q <= '0;
      if (soft_rst_i) begin
        state_q <= ST_IDLE;
        busy_q  <= 1'b0;
        oe_q    <= 1'b0;
        cnt_q   <= '0;
      end else if (stop_i) begin
        evt_q[EV_STOP] <= busy_q;
        state_q <= ST_IDLE;
        busy_q  <= 1'b0;
        oe_q    <= 1'b0;
      end else if (start_i) begin
        evt_q[EV_START] <= 1'b1;
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR: begin
            if (scl_rise_i) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == CNT_W'(BYTE_W)) begin
              cnt_q <= '0;
              if (sh_q[BYTE_W-1:1] == own_addr_i) begin
                state_q <= ST_AACK;
                oe_q    <= 1'b1;
                busy_q  <= 1'b1;
                rw_q    <= sh_q[0];
              end else begin
                state_q <= ST_SKIP;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall_i) begin
              cnt_q <= '0;
              if (rw_q) begin
                state_q <= ST_TX;
                sh_q    <= tx_data_i;
                oe_q    <= ~tx_data_i[BYTE_W-1];
              end else begin
                state_q <= ST_RX;
                oe_q    <= 1'b0;
              end
            end
          end
          ST_RX: begin
            if (scl_rise_i) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == CNT_W'(BYTE_W)) begin
              evt_q[EV_RX] <= 1'b1;
              rx_data_o    <= sh_q;
              state_q      <= ST_RACK;
              oe_q         <= ~ack_cfg_i;
              cnt_q        <= '0;
            end
          end
          ST_RACK: begin
            if (scl_fall_i) begin
              oe_q    <= 1'b0;
              state_q <= ST_RX;
            end
          end
          ST_TX: begin
            if (scl_fall_i) begin
              if (cnt_q == CNT_W'(BYTE_W - 1)) begin
                evt_q[EV_TX] <= 1'b1;
                state_q      <= ST_TACK;
                oe_q         <= 1'b0;
                cnt_q        <= '0;
              end else begin
                cnt_q <= cnt_q + 1'b1;
                sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
                oe_q  <= ~sh_q[BYTE_W-2];
              end
            end
          end
          ST_TACK: begin
            if (scl_rise_i) begin
              ack_in_q <= sda_i;
            end else if (scl_fall_i) begin
              if (!ack_in_q) begin
                state_q <= ST_TX;
                sh_q    <= tx_data_i;
                oe_q    <= ~tx_data_i[BYTE_W-1];
              end else begin
                state_q <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign busy_o   = busy_q;
  assign sda_oe_o = oe_q;
  assign ack_in_o = ack_in_q;
  assign evt_o    = evt_q;

  p_busy_from_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(state_q) == ST_ADDR);
  p_idle_released_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_IDLE |-> !oe_q);
  p_stop_to_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !soft_rst_i) |=> (!busy_q && state_q == ST_IDLE));
  p_rx_on_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q[EV_RX] |-> $past(scl_fall_i));
  p_soft_rst_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (!busy_q && !oe_q));
endmodule

// File: rtl/i2c_evt_slave.sv
module i2c_evt_slave
  import i2c_evt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_we_i,
  input  logic [1:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic       irq_o
);
  logic              s_scl, s_sda;
  logic              scl_rise, scl_fall, start_det, stop_det;
  logic              busy, ack_in;
  logic [BYTE_W-1:0] rx_data;
  logic [EV_N-1:0]   evt;

  logic [EV_N-1:0]   en_q, flag_q, clr_mask;
  logic              ack_cfg_q;
  logic [ADDR_W-1:0] own_addr_q;
  logic [BYTE_W-1:0] tx_data_q;
  logic              soft_rst;

  i2c_evt_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   ({scl_i, sda_i}),
    .out_o  ({s_scl, s_sda})
  );

  i2c_evt_cond u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (s_scl),
    .sda_i      (s_sda),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_evt_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst),
    .sda_i      (s_sda),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .own_addr_i (own_addr_q),
    .tx_data_i  (tx_data_q),
    .ack_cfg_i  (ack_cfg_q),
    .busy_o     (busy),
    .sda_oe_o   (sda_oe_o),
    .ack_in_o   (ack_in),
    .rx_data_o  (rx_data),
    .evt_o      (evt)
  );

  assign soft_rst = reg_we_i && reg_addr_i == RA_CTRL && reg_wdata_i[0];
  assign clr_mask = (reg_we_i && reg_addr_i == RA_STAT) ? ~reg_wdata_i[6:3] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= '0;
      flag_q     <= '0;
      ack_cfg_q  <= 1'b0;
      own_addr_q <= '0;
      tx_data_q  <= '0;
    end else begin
      // new events win over a same-cycle clear
      flag_q <= (flag_q & ~clr_mask) | evt;
      if (reg_we_i) begin
        unique case (reg_addr_i)
          RA_CTRL: en_q       <= reg_wdata_i[6:3];
          RA_STAT: ack_cfg_q  <= reg_wdata_i[0];
          RA_SADR: own_addr_q <= reg_wdata_i[ADDR_W-1:0];
          RA_DATA: tx_data_q  <= reg_wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      RA_CTRL: reg_rdata_o = {1'b0, en_q, 3'b000};
      RA_STAT: reg_rdata_o = {busy, flag_q, 1'b0, ack_in, ack_cfg_q};
      RA_SADR: reg_rdata_o = {1'b0, own_addr_q};
      RA_DATA: reg_rdata_o = rx_data;
      default: reg_rdata_o = '0;
    endcase
  end

  assign irq_o = |(flag_q & en_q);

  p_flag_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(flag_q) & ~$past(clr_mask)) & ~flag_q) == '0);
  p_irq_source_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (en_q != '0 && flag_q != '0));
endmodule

// File: tb/i2c_evt_slave_tb.sv
module i2c_evt_slave_tb;
  localparam int H = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_line;
  logic       sda_oe;
  logic       irq;

  int vectors = 0;
  int errors  = 0;

  // behavioural model
  bit       m_busy;
  bit [3:0] m_flags;   // {start, rx, tx, stop}
  bit [3:0] m_en;
  bit       m_ack_in;
  bit       m_ack_cfg;

  assign sda_line = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  i2c_evt_slave u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .scl_i       (scl),
    .sda_i       (sda_line),
    .sda_oe_o    (sda_oe),
    .irq_o       (irq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int got, input int exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    tick(2);
  endtask

  task automatic model_stat_write(input logic [7:0] d);
    m_flags   = m_flags & d[6:3];
    m_ack_cfg = d[0];
  endtask

  task automatic cmp_state(input string req);
    logic [7:0] st;
    rd(2'd1, st);
    chk(req, st, {m_busy, m_flags, 1'b0, m_ack_in, m_ack_cfg});
    chk(req, irq, |(m_flags & m_en));
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_m = b;
    tick(H);
    scl = 1'b1;
    tick(H/2);
    s = sda_line;
    tick(H/2);
    scl = 1'b0;
    tick(2);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl = 1'b1;
    tick(H);
    sda_m = 1'b0;
    tick(H);
    scl = 1'b0;
    tick(H);
    m_flags[3] = 1'b1;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0;
    tick(H);
    scl = 1'b1;
    tick(H);
    sda_m = 1'b1;
    tick(H);
    if (m_busy) m_flags[0] = 1'b1;
    m_busy = 1'b0;
  endtask

  task automatic send8(input logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send8(b);
    clk_bit(1'b1, ack);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      d[i] = s;
    end
    clk_bit(mack, s);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    logic       ack;
    tick(4);
    rst_n = 1'b1;
    tick(4);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      chk("R1", d, 0);
    end
    chk("R1", irq, 0);
    chk("R1", sda_oe, 0);

    // R9 enables and own address
    wr(2'd2, 8'h2A);
    wr(2'd0, 8'h78); m_en = 4'hF;
    rd(2'd0, d); chk("R9", d, 8'h78);
    rd(2'd2, d); chk("R3", d, 8'h2A);

    // R2 start flag, R9 irq
    bus_start();
    cmp_state("R2");

    // R8 write 1 no effect, R11 busy read-only
    wr(2'd1, 8'hFE); model_stat_write(8'hFE);
    cmp_state("R8");
    wr(2'd1, 8'h80); model_stat_write(8'h80);
    cmp_state("R11");

    // R3 address mismatch
    send_byte({7'h2B, 1'b0}, ack);
    chk("R3", ack, 1);
    cmp_state("R3");
    bus_stop();
    cmp_state("R4");

    // R9 gating: flag set, enable clear
    wr(2'd0, 8'h00); m_en = 4'h0;
    bus_start();
    cmp_state("R9");
    wr(2'd0, 8'h78); m_en = 4'hF;
    cmp_state("R9");
    wr(2'd1, 8'h00); model_stat_write(8'h00);

    // R3 match, R5 receive, R6 ack control
    send_byte({7'h2A, 1'b0}, ack);
    chk("R3", ack, 0);
    m_busy = 1'b1;
    cmp_state("R3");
    send_byte(8'hA5, ack);
    m_flags[2] = 1'b1;
    chk("R6", ack, 0);
    rd(2'd3, d); chk("R5", d, 8'hA5);
    cmp_state("R5");
    wr(2'd1, 8'h01); model_stat_write(8'h01);
    send_byte(8'h3C, ack);
    m_flags[2] = 1'b1;
    chk("R6", ack, 1);
    rd(2'd3, d); chk("R5", d, 8'h3C);
    cmp_state("R5");
    wr(2'd1, 8'h00); model_stat_write(8'h00);
    bus_stop();
    cmp_state("R4");
    wr(2'd1, 8'h00); model_stat_write(8'h00);

    // R7 transmit
    wr(2'd3, 8'hC3);
    bus_start();
    send_byte({7'h2A, 1'b1}, ack);
    chk("R7", ack, 0);
    m_busy = 1'b1;
    recv_byte(1'b0, d);
    chk("R7", d, 8'hC3);
    m_flags[1] = 1'b1; m_ack_in = 1'b0;
    cmp_state("R7");
    recv_byte(1'b1, d);
    chk("R7", d, 8'hC3);
    m_flags[1] = 1'b1; m_ack_in = 1'b1;
    cmp_state("R7");
    chk("R7", sda_oe, 0);
    bus_stop();
    cmp_state("R4");
    wr(2'd1, 8'h00); model_stat_write(8'h00);

    // R10 soft reset while driving the ACK slot
    bus_start();
    send8({7'h2A, 1'b0});
    tick(H);
    chk("R10", sda_oe, 1);
    wr(2'd0, 8'h79);
    chk("R10", sda_oe, 0);
    rd(2'd0, d); chk("R10", d, 8'h78);
    cmp_state("R10");
    bus_stop();
    cmp_state("R10");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule